// File: doc/BRIEF.md
# Command-Programmable March Memory BIST Engine

This block runs a march-style self-test on a single-port synchronous RAM. The algorithm is not built in. A small buffer of test commands is loaded over a one-bit serial input, and the engine then runs the commands in turn. Each command gives an address direction, a short read/write operation sequence and a data background. For every address in the chosen order, the engine applies the whole sequence. Writes drive the background or its complement. Each read is checked on the following cycle against the value the sequence predicts.

The block has two parts. A front controller accepts the serial load and starts a run when loading stops. A back generator fetches a command, executes it, compares the read data and records the verdict. When a run finishes, `done_o` rises. `go_o` then tells whether every read matched. The first mismatch ends the run at once. The RAM's read data must arrive one cycle after a read is issued.

Top module: `mbist_engine`

## Requirements
- R1: After reset, `done_o`, `go_o`, `ram_en_o` and `ram_we_o` are all low.
- R2: Each clock with `shift_i` high shifts `sdi_i` into a buffer of NCMD commands of 5+DW bits each. The first bit shifted becomes bit 0 of slot 0, and the last becomes the top bit of slot NCMD-1. Within a command, bit 0 is the direction (0 ascending, 1 descending), bits 4..1 are the opcode, and bits 5 and up hold the background. Loading clears `done_o` and `go_o`.
- R3: A run starts on the first clock with `shift_i` low after a load. Slots execute from 0 upward. The run stops at the first slot whose opcode is 0 (null), or after slot NCMD-1. No RAM access occurs outside a run.
- R4: Opcodes select these sequences, where A is the background and N its complement: 1 wA; 2 wN; 3 rA; 4 rN; 5 rA wN; 6 rN wA; 7 rA wN rN; 8 rN wA rA; 9 wA rA wN rN; 10 wN rN wA rA; 11 rA wA; 12 rN wN; 13 wA rA; 14 wN rN; 15 rA wN rN wA.
- R5: An ascending command visits addresses 0 to DEPTH-1, and a descending one visits DEPTH-1 down to 0. The whole sequence is applied to one address before the next address is visited.
- R6: A write drives the sequence's data on `ram_wdata_o` with `ram_we_o` high. A read drives `ram_we_o` low, and the data returned in the next cycle is compared with A or N as the sequence specifies.
- R7: On the first mismatch, `done_o` goes high and `go_o` low. No further RAM access follows.
- R8: If every read matches, the run ends with `done_o` and `go_o` both high. Both hold until the next load.
- R9: For a passing run, `done_o` is first seen high after 5 + sum over executed commands of (2 + DEPTH*(writes + 2*reads)) clocks. Counting starts with the first clock at which `shift_i` is low.
- R10: `shift_i` and `sdi_i` are ignored while a run is in progress. They change neither the buffer nor the access stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_i | input | 1 | Serial load strobe; a falling level starts a run |
| sdi_i | input | 1 | Serial command data, first bit lands in slot 0 bit 0 |
| done_o | output | 1 | Run finished |
| go_o | output | 1 | Pass flag, valid with done_o |
| ram_en_o | output | 1 | RAM access strobe |
| ram_we_o | output | 1 | RAM write (1) or read (0) |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, one cycle after a read |

## Verification
Most wrong internal states show up on the RAM side within one access. Examples are a stale slot pointer, a step counter that skips an operation, an address stepping the wrong way, or a background left uncomplemented. Each of these changes the direction, address or data of the very next strobe, so the bench compares every access against a trace it predicts. A wrong compare register or a lost verdict shows up only at the end, as `go_o` disagreeing with the model or `done_o` arriving off the predicted cycle count. A controller that leaves the apply state too early or too late shows up as a shifted latency or as accesses after `done_o`.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int OPC_LSB = 1;
  localparam int OPC_W   = 4;
  localparam int BG_LSB  = OPC_LSB + OPC_W;

  typedef struct packed {
    logic rd;
    logic inv;
  } mop_t;

  typedef struct packed {
    logic [2:0]      len;
    mop_t [3:0]      ops;
  } mseq_t;

  typedef enum logic [1:0] {C_IDLE, C_SHIFT, C_GET, C_APPLY} cst_t;
  typedef enum logic [2:0] {G_IDLE, G_INIT, G_IFETCH, G_DFETCH, G_EXEC, G_CMP, G_NOGO} gst_t;

  localparam mop_t M_WA = '{rd: 1'b0, inv: 1'b0};
  localparam mop_t M_WN = '{rd: 1'b0, inv: 1'b1};
  localparam mop_t M_RA = '{rd: 1'b1, inv: 1'b0};
  localparam mop_t M_RN = '{rd: 1'b1, inv: 1'b1};

  // ops[0] executes first
  function automatic mseq_t decode_op(input logic [OPC_W-1:0] opc);
    mseq_t s;
    s = '0;
    case (opc)
      4'd1:  begin s.len = 3'd1; s.ops[0] = M_WA; end
      4'd2:  begin s.len = 3'd1; s.ops[0] = M_WN; end
      4'd3:  begin s.len = 3'd1; s.ops[0] = M_RA; end
      4'd4:  begin s.len = 3'd1; s.ops[0] = M_RN; end
      4'd5:  begin s.len = 3'd2; s.ops[0] = M_RA; s.ops[1] = M_WN; end
      4'd6:  begin s.len = 3'd2; s.ops[0] = M_RN; s.ops[1] = M_WA; end
      4'd7:  begin s.len = 3'd3; s.ops[0] = M_RA; s.ops[1] = M_WN; s.ops[2] = M_RN; end
      4'd8:  begin s.len = 3'd3; s.ops[0] = M_RN; s.ops[1] = M_WA; s.ops[2] = M_RA; end
      4'd9:  begin s.len = 3'd4; s.ops[0] = M_WA; s.ops[1] = M_RA; s.ops[2] = M_WN; s.ops[3] = M_RN; end
      4'd10: begin s.len = 3'd4; s.ops[0] = M_WN; s.ops[1] = M_RN; s.ops[2] = M_WA; s.ops[3] = M_RA; end
      4'd11: begin s.len = 3'd2; s.ops[0] = M_RA; s.ops[1] = M_WA; end
      4'd12: begin s.len = 3'd2; s.ops[0] = M_RN; s.ops[1] = M_WN; end
      4'd13: begin s.len = 3'd2; s.ops[0] = M_WA; s.ops[1] = M_RA; end
      4'd14: begin s.len = 3'd2; s.ops[0] = M_WN; s.ops[1] = M_RN; end
      4'd15: begin s.len = 3'd4; s.ops[0] = M_RA; s.ops[1] = M_WN; s.ops[2] = M_RN; s.ops[3] = M_WA; end
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/mbist_cmd_ctrl.sv
module mbist_cmd_ctrl
  import mbist_pkg::*;
#(
  parameter int NCMD  = 4,
  parameter int CMD_W = 13,
  localparam int TOT  = NCMD * CMD_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic           sdi_i,
  input  logic           fin_i,
  output logic [TOT-1:0] cmd_buf_o,
  output logic           ena_o,
  output logic           clr_o
);
  cst_t st_q;
  logic accept;

  assign accept = shift_i && (st_q == C_IDLE || st_q == C_SHIFT);
  assign ena_o  = (st_q == C_APPLY);
  assign clr_o  = accept;

  // first bit in ends at bit 0 after TOT shifts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_buf_o <= '0;
    else if (accept) cmd_buf_o <= {sdi_i, cmd_buf_o[TOT-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= C_IDLE;
    else begin
      case (st_q)
        C_IDLE:  if (shift_i) st_q <= C_SHIFT;
        C_SHIFT: if (!shift_i) st_q <= C_GET;
        C_GET:   st_q <= C_APPLY;
        C_APPLY: if (fin_i) st_q <= C_IDLE;
        default: st_q <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbist_seq_gen.sv
module mbist_seq_gen
  import mbist_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int NCMD  = 4,
  parameter int AW    = 4,
  parameter int CMD_W = 13,
  localparam int PW   = $clog2(NCMD + 1),
  localparam int IW   = (NCMD > 1) ? $clog2(NCMD) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ena_i,
  input  logic                  clr_i,
  input  logic [NCMD*CMD_W-1:0] cmd_buf_i,
  input  logic [DW-1:0]         ram_rdata_i,
  output logic                  ram_en_o,
  output logic                  ram_we_o,
  output logic [AW-1:0]         ram_addr_o,
  output logic [DW-1:0]         ram_wdata_o,
  output logic                  done_o,
  output logic                  go_o,
  output logic                  fin_o
);
  localparam logic [AW-1:0] TOP_A = AW'(DEPTH - 1);

  logic [CMD_W-1:0] cmd_slot [NCMD];
  for (genvar k = 0; k < NCMD; k++) begin : g_slot
    assign cmd_slot[k] = cmd_buf_i[k*CMD_W +: CMD_W];
  end

  gst_t            st_q;
  logic            ena_q, dir_q, done_q, go_q, fin_q;
  logic [PW-1:0]   ptr_q;
  mseq_t           seq_q;
  logic [DW-1:0]   bg_q, exp_q;
  logic [AW-1:0]   addr_q, addr_nx;
  logic [1:0]      step_q, step_nx;
  logic            ptr_ok, last_op, last_addr, wrap;
  logic [CMD_W-1:0] cur_cmd;
  mop_t            cur_op;
  logic [DW-1:0]   op_data;

  assign ptr_ok  = (ptr_q < PW'(NCMD));
  assign cur_cmd = ptr_ok ? cmd_slot[ptr_q[IW-1:0]] : '0;
  assign cur_op  = seq_q.ops[step_q];
  assign op_data = cur_op.inv ? ~bg_q : bg_q;

  always_comb begin
    last_op   = ({1'b0, step_q} == (seq_q.len - 3'd1));
    last_addr = dir_q ? (addr_q == '0) : (addr_q == TOP_A);
    wrap      = last_op && last_addr;
    step_nx   = last_op ? 2'd0 : step_q + 2'd1;
    addr_nx   = addr_q;
    if (last_op && !last_addr) addr_nx = dir_q ? addr_q - 1'b1 : addr_q + 1'b1;
  end

  assign ram_en_o    = (st_q == G_EXEC);
  assign ram_we_o    = ram_en_o && !cur_op.rd;
  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = op_data;
  assign done_o      = done_q;
  assign go_o        = go_q;
  assign fin_o       = fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= G_IDLE; ena_q <= 1'b0; dir_q <= 1'b0; done_q <= 1'b0; go_q <= 1'b0;
      fin_q <= 1'b0; ptr_q <= '0; seq_q <= '0; bg_q <= '0; exp_q <= '0;
      addr_q <= '0; step_q <= '0;
    end else begin
      ena_q <= ena_i;
      fin_q <= 1'b0;
      case (st_q)
        G_IDLE: if (ena_i && !ena_q) st_q <= G_INIT;
        G_INIT: begin
          ptr_q <= '0; done_q <= 1'b0; go_q <= 1'b1; st_q <= G_IFETCH;
        end
        G_IFETCH: begin
          if (!ptr_ok || cur_cmd[OPC_LSB +: OPC_W] == '0) begin
            done_q <= 1'b1; fin_q <= 1'b1; st_q <= G_IDLE;
          end else begin
            dir_q <= cur_cmd[0];
            seq_q <= decode_op(cur_cmd[OPC_LSB +: OPC_W]);
            bg_q  <= cur_cmd[BG_LSB +: DW];
            st_q  <= G_DFETCH;
          end
        end
        G_DFETCH: begin
          addr_q <= dir_q ? TOP_A : '0; step_q <= '0; st_q <= G_EXEC;
        end
        G_EXEC: begin
          if (cur_op.rd) begin
            exp_q <= op_data; st_q <= G_CMP;
          end else begin
            step_q <= step_nx; addr_q <= addr_nx;
            if (wrap) begin ptr_q <= ptr_q + PW'(1); st_q <= G_IFETCH; end
            else st_q <= G_EXEC;
          end
        end
        G_CMP: begin
          if (ram_rdata_i != exp_q) begin
            go_q <= 1'b0; done_q <= 1'b1; fin_q <= 1'b1; st_q <= G_NOGO;
          end else begin
            step_q <= step_nx; addr_q <= addr_nx;
            if (wrap) begin ptr_q <= ptr_q + PW'(1); st_q <= G_IFETCH; end
            else st_q <= G_EXEC;
          end
        end
        G_NOGO: if (!ena_i) st_q <= G_IDLE;
        default: st_q <= G_IDLE;
      endcase
      if (clr_i) begin
        done_q <= 1'b0; go_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
  import mbist_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int NCMD  = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          sdi_i,
  output logic          done_o,
  output logic          go_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i
);
  localparam int CMD_W = BG_LSB + DW;

  logic [NCMD*CMD_W-1:0] cmd_buf;
  logic ena, clr, fin;

  mbist_cmd_ctrl #(.NCMD(NCMD), .CMD_W(CMD_W)) u_ctrl (
    .clk_i, .rst_ni, .shift_i, .sdi_i,
    .fin_i(fin), .cmd_buf_o(cmd_buf), .ena_o(ena), .clr_o(clr)
  );

  mbist_seq_gen #(.DEPTH(DEPTH), .DW(DW), .NCMD(NCMD), .AW(AW), .CMD_W(CMD_W)) u_gen (
    .clk_i, .rst_ni, .ena_i(ena), .clr_i(clr), .cmd_buf_i(cmd_buf),
    .ram_rdata_i, .ram_en_o, .ram_we_o, .ram_addr_o, .ram_wdata_o,
    .done_o, .go_o, .fin_o(fin)
  );
endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ena,
  input logic          clr,
  input logic          done_o,
  input logic          go_o,
  input logic          ram_en_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ram_addr_o
);
  assert_access_in_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> ena);

  assert_addr_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> (32'(ram_addr_o) < DEPTH));

  assert_we_strobed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_en_o);

  assert_quiet_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ram_en_o);

  assert_go_drop_ends_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(go_o) && !$past(clr)) |-> done_o);

  assert_done_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr) |=> done_o);
endmodule

bind mbist_engine mbist_engine_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ena(ena), .clr(clr), .done_o(done_o),
  .go_o(go_o), .ram_en_o(ram_en_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o)
);

// File: tb/tb_mbist_engine.sv
module tb_mbist_engine;
  localparam int DEPTH  = 16;
  localparam int DW     = 8;
  localparam int NCMD   = 4;
  localparam int AW     = 4;
  localparam int CMD_W  = 5 + DW;
  localparam int MAXOPS = NCMD * DEPTH * 4;

  logic clk = 1'b0, rst_n = 1'b0, shift = 1'b0, sdi = 1'b0;
  logic done, go, ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, rdata;

  always #10 clk = ~clk;

  mbist_engine #(.DEPTH(DEPTH), .DW(DW), .NCMD(NCMD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .shift_i(shift), .sdi_i(sdi),
    .done_o(done), .go_o(go), .ram_en_o(ram_en), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(rdata)
  );

  int checks = 0, fails = 0, cyc = 0;

  // RAM model with one optional stuck bit
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] pre [DEPTH];
  logic preload = 1'b0;
  bit f_en = 0, f_val = 0;
  int f_addr = 0, f_bit = 0;

  function automatic logic [DW-1:0] hit(input logic [DW-1:0] d, input int a);
    logic [DW-1:0] r = d;
    if (f_en && a == f_addr) r[f_bit] = f_val;
    return r;
  endfunction

  always @(posedge clk) begin
    if (preload) for (int i = 0; i < DEPTH; i++) mem[i] <= pre[i];
    else if (ram_en && ram_we) mem[ram_addr] <= hit(ram_wdata, int'(ram_addr));
    if (ram_en && !ram_we) rdata <= mem[ram_addr];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // opcode table written as op letter + data letter (a = background, n = complement)
  function automatic string pat_of(input int op);
    case (op)
      1: return "wa";       2: return "wn";       3: return "ra";       4: return "rn";
      5: return "rawn";     6: return "rnwa";     7: return "rawnrn";   8: return "rnwara";
      9: return "warawnrn"; 10: return "wnrnwara"; 11: return "rawa";   12: return "rnwn";
      13: return "wara";    14: return "wnrn";    15: return "rawnrnwa";
      default: return "";
    endcase
  endfunction

  function automatic logic [CMD_W-1:0] mk(input int op, input bit desc, input logic [DW-1:0] bg);
    return {bg, 4'(op), desc};
  endfunction

  logic [CMD_W-1:0] prog [NCMD];
  bit            e_we [MAXOPS];
  int            e_addr [MAXOPS];
  logic [DW-1:0] e_data [MAXOPS];
  int n_exp, e_cyc;
  bit e_go;

  task automatic build();
    logic [DW-1:0] sm [DEPTH];
    bit stop = 0;
    for (int i = 0; i < DEPTH; i++) sm[i] = pre[i];
    n_exp = 0; e_go = 1; e_cyc = 5;
    for (int c = 0; c < NCMD; c++) begin
      int op = int'(prog[c][4:1]);
      bit desc = prog[c][0];
      logic [DW-1:0] bg = prog[c][CMD_W-1:5];
      string p;
      int nops, nrd;
      if (stop || op == 0) break;
      p = pat_of(op); nops = p.len() / 2; nrd = 0;
      for (int s = 0; s < nops; s++) if (p[2*s] == "r") nrd++;
      e_cyc += 2 + DEPTH * (nops + nrd);
      for (int i = 0; i < DEPTH; i++) begin
        int a = desc ? DEPTH - 1 - i : i;
        for (int s = 0; s < nops; s++) begin
          logic [DW-1:0] d = (p[2*s+1] == "n") ? ~bg : bg;
          bit rd = (p[2*s] == "r");
          e_we[n_exp] = !rd; e_addr[n_exp] = a; e_data[n_exp] = d; n_exp++;
          if (!rd) sm[a] = hit(d, a);
          else if (sm[a] != d) begin e_go = 0; stop = 1; end
          if (stop) break;
        end
        if (stop) break;
      end
    end
  endtask

  task automatic run(input bit noise, input string tag);
    logic [NCMD*CMD_W-1:0] bits;
    int k = 0, cnt = 0;
    for (int c = 0; c < NCMD; c++) bits[c*CMD_W +: CMD_W] = prog[c];
    build();
    @(negedge clk); preload = 1'b1;
    @(negedge clk); preload = 1'b0;
    for (int b = 0; b < NCMD*CMD_W; b++) begin
      @(negedge clk); shift = 1'b1; sdi = bits[b];
    end
    @(negedge clk);
    check(done == 1'b0 && go == 1'b0, "R2", {tag, " load clears done/go"}, {done, go}, 0);
    shift = 1'b0;
    forever begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (ram_en) begin
        if (k < n_exp) begin
          check(ram_we == e_we[k], "R4", {tag, " op kind"}, ram_we, e_we[k]);
          check(int'(ram_addr) == e_addr[k], "R5", {tag, " address"}, ram_addr, e_addr[k]);
          if (e_we[k]) check(ram_wdata == e_data[k], "R6", {tag, " write data"}, ram_wdata, e_data[k]);
        end else check(0, "R7", {tag, " access beyond expected"}, k, n_exp);
        k++;
      end
      if (done) break;
      if (noise) begin shift = 1'($urandom); sdi = 1'($urandom); end
      if (cnt > 5000) begin check(0, "R3", {tag, " run never ended"}, cnt, e_cyc); break; end
    end
    shift = 1'b0; sdi = 1'b0;
    check(k == n_exp, "R3", {tag, " access count"}, k, n_exp);
    if (noise) check(k == n_exp && go == e_go, "R10", {tag, " serial input ignored in run"}, go, e_go);
    if (e_go) begin
      check(go == 1'b1, "R8", {tag, " pass verdict"}, go, 1);
      check(cnt == e_cyc, "R9", {tag, " latency"}, cnt, e_cyc);
    end else
      check(go == 1'b0, "R7", {tag, " fail verdict"}, go, 0);
    repeat (3) begin
      @(negedge clk);
      check(!ram_en && done && go == e_go, "R8", {tag, " idle hold"}, {ram_en, done, go}, {1'b0, 1'b1, e_go});
    end
  endtask

  task automatic fill_pre(input bit rnd);
    for (int i = 0; i < DEPTH; i++) pre[i] = rnd ? DW'($urandom) : '0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    fill_pre(0);
    #5;
    check(!done && !go && !ram_en && !ram_we, "R1", "outputs in reset", {done, go, ram_en, ram_we}, 0);
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!done && !go && !ram_en && !ram_we, "R1", "outputs after reset", {done, go, ram_en, ram_we}, 0);

    // march-like program, clean memory
    prog[0] = mk(1, 0, 8'h00); prog[1] = mk(5, 0, 8'h00);
    prog[2] = mk(6, 1, 8'h00); prog[3] = mk(3, 1, 8'h00);
    f_en = 0; run(0, "march clean");

    // same with stuck-at-1 in the middle of the array
    f_en = 1; f_addr = 7; f_bit = 3; f_val = 1; run(0, "march stuck1");
    f_en = 1; f_addr = 0; f_bit = 0; f_val = 0; run(0, "march stuck0 edge");

    // null in slot 0
    f_en = 0; prog[0] = mk(0, 0, 8'hFF); run(0, "null first");

    // null in slot 2, slot 3 must not run (R3)
    prog[0] = mk(9, 1, 8'h55); prog[1] = mk(7, 0, 8'h55);
    prog[2] = mk(0, 0, 8'h00); prog[3] = mk(2, 0, 8'hAA);
    run(0, "null middle");

    // every slot used, richer sequences
    prog[0] = mk(10, 0, 8'h33); prog[1] = mk(15, 1, 8'h0F);
    prog[2] = mk(8, 0, 8'h0F);  prog[3] = mk(14, 1, 8'hC3);
    run(0, "full buffer");

    // serial inputs toggling during the run
    run(1, "noise");
    f_en = 1; f_addr = 15; f_bit = 7; f_val = 0; run(1, "noise fail");

    for (int r = 0; r < 10; r++) begin
      fill_pre(1);
      prog[0] = mk(1 + ($urandom % 2), 1'($urandom), DW'($urandom));
      for (int c = 1; c < NCMD; c++)
        prog[c] = mk(($urandom % 5 == 0) ? 0 : 1 + ($urandom % 15), 1'($urandom), DW'($urandom));
      f_en = ($urandom % 2 == 0); f_addr = $urandom % DEPTH; f_bit = $urandom % DW; f_val = 1'($urandom);
      run(r % 3 == 0, "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule